// File: doc/BRIEF.md
# Fixed-Length Burst Read Controller with Wait Pacing

This block runs read accesses on a synchronous external memory bus on behalf of a host. The host presents a one-cycle request naming a chip select and an address. The controller then runs one access. First comes an address phase, with the chip select low and the address strobe low for one cycle. Then comes a data phase, with the output enable low, during which data beats are captured from the bus and handed to the host.

Each chip select has its own configuration, which is sampled when the request is accepted. That configuration holds:
- a burst enable;
- a two-bit length code;
- a choice among the wait (ready) inputs;
- a polarity invert for that wait input;
- a monitoring delay of 0 to 2 bus cycles.

With burst enabled, every access is a full burst of the configured length. The length is never sent to the device. Otherwise every access is one beat. A beat is captured only when the selected wait input has been quiet long enough, so a slow device can stretch any beat. The controller looks at the wait inputs only during the data phase.

Top module: `bwc_burst_ctrl`

## Requirements
- R1: After reset, every chip select, the address strobe and the output enable are high (inactive), and `rsp_valid`, `rsp_last` and `req_ack` are low.
- R2: A request sampled while idle starts an access. In the next cycle, only the requested chip select is low, the address strobe is low for exactly that one cycle, and `bus_addr` holds the request address. From the following cycle on, the output enable is low and the address strobe is high until the access ends.
- R3: With the burst enable of the chip select cleared, an access delivers exactly one beat, flagged with `rsp_last`.
- R4: With the burst enable set, an access delivers a fixed number of beats, set by the length code: 0 gives 4, 1 gives 8, 2 gives 16, and 3 gives 4. `rsp_last` is high on the final beat only.
- R5: The selected wait is active when the chosen `wait_in` bit, XORed with the invert bit, is 1. A data-phase clock edge captures a beat when wait is inactive at that edge and the wait was also inactive at the immediately preceding data-phase edges, at least D of them in a row. D is the monitoring delay code, with code 3 treated as 2. The count starts at the beginning of the data phase and restarts after every edge at which wait is active.
- R6: An active wait holds the beat for as long as it lasts, and each later beat is paced by the same rule. Wait may become active again right after a beat is captured, with no minimum gap.
- R7: The wait-select field (2 bits) picks which `wait_in` bit the access uses. The other wait inputs have no effect on it.
- R8: Wait levels during idle and during the address phase have no effect on when the beats are captured.
- R9: Each beat raises `rsp_valid` for one cycle, with `rsp_data` equal to `bus_rdata` at the capturing edge. In the cycle of the final beat, `req_ack` is high and all chip selects and the output enable are already released.
- R10: A request presented while an access is in progress is ignored. The controller is idle in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle read request |
| req_cs | input | 2 | Chip select of the request |
| req_addr | input | 16 | Start address of the request |
| req_ack | output | 1 | Pulse on completion of the access |
| cfg_burst | input | 4 | Burst enable, one bit per chip select |
| cfg_len | input | 8 | Length code, 2 bits per chip select |
| cfg_wsel | input | 8 | Wait-input select, 2 bits per chip select |
| cfg_winv | input | 4 | Wait polarity invert, one bit per chip select |
| cfg_wdly | input | 8 | Monitoring delay code, 2 bits per chip select |
| wait_in | input | 4 | Wait inputs from the devices |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_adv_n | output | 1 | Address strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_addr | output | 16 | Address to the device |
| bus_rdata | input | 16 | Read data from the device |
| rsp_valid | output | 1 | Beat valid toward the host |
| rsp_last | output | 1 | Final beat of the access |
| rsp_data | output | 16 | Beat data |

## Verification
The pacing logic is tried with four wait patterns:
- Wait never active shows whether the monitoring delay alone spaces the first beat and lets later beats run back to back.
- Light random wait tells a delay counter that restarts after every active sample apart from one that does not.
- Heavy random wait stresses long holds in the middle of a burst.
- A directed pattern holds wait for the first cycles and then raises it again in the cycle right after each capture, which shows that a re-asserted wait is honoured with no gap and re-paced.

All wait inputs that are not selected, and the wait levels during idle and the address phase, are driven randomly, so that reading the wrong input or the wrong phase shows up as beats at the wrong time. Every length code, including the reserved one, is run. Requests are poked into running accesses.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bwc_state_e;

  localparam int BEAT_W = 5;

  // Beats per access: single mode gives 1, burst codes 0/1/2 give 4/8/16, code 3 gives 4
  function automatic logic [BEAT_W-1:0] beats_of(input logic burst, input logic [1:0] code);
    if (!burst) return BEAT_W'(1);
    case (code)
      2'd1:    return BEAT_W'(8);
      2'd2:    return BEAT_W'(16);
      default: return BEAT_W'(4);
    endcase
  endfunction

  // Monitoring delay in cycles, capped at 2
  function automatic logic [1:0] dly_of(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/bwc_wait_sel.sv
module bwc_wait_sel #(
  parameter int NUM_WAIT = 4,
  localparam int SEL_W = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1
) (
  input  logic [NUM_WAIT-1:0] wait_in,
  input  logic [SEL_W-1:0]    sel,
  input  logic                inv,
  output logic                wait_act
);
  assign wait_act = wait_in[sel] ^ inv;
endmodule

// File: rtl/bwc_pace.sv
module bwc_pace (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       in_data,
  input  logic       wait_act,
  input  logic [1:0] dly,
  output logic       take
);
  logic [1:0] quiet;

  assign take = in_data && !wait_act && (quiet >= dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet <= 2'd0;
    end else if (restart) begin
      quiet <= 2'd0;
    end else if (in_data) begin
      if (wait_act)           quiet <= 2'd0;
      else if (quiet != 2'd2) quiet <= quiet + 2'd1;
    end
  end

  // R6
  wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && wait_act && !restart) |=> !take || (dly == 2'd0));
endmodule

// File: rtl/bwc_beat_cnt.sv
module bwc_beat_cnt
  import bwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              take,
  input  logic [BEAT_W-1:0] len,
  output logic              final_beat
);
  logic [BEAT_W-1:0] cnt;

  assign final_beat = take && (cnt == len - BEAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (final_beat)      cnt <= '0;
    else if (take)            cnt <= cnt + BEAT_W'(1);
  end

  // R4
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len));
endmodule

// File: rtl/bwc_burst_ctrl.sv
module bwc_burst_ctrl
  import bwc_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int NUM_WAIT = 4,
  parameter int AW       = 16,
  parameter int DW       = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int SEL_W = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [AW-1:0]           req_addr,
  output logic                    req_ack,
  input  logic [NUM_CS-1:0]       cfg_burst,
  input  logic [2*NUM_CS-1:0]     cfg_len,
  input  logic [SEL_W*NUM_CS-1:0] cfg_wsel,
  input  logic [NUM_CS-1:0]       cfg_winv,
  input  logic [2*NUM_CS-1:0]     cfg_wdly,
  input  logic [NUM_WAIT-1:0]     wait_in,
  output logic [NUM_CS-1:0]       bus_cs_n,
  output logic                    bus_adv_n,
  output logic                    bus_oe_n,
  output logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_last,
  output logic [DW-1:0]           rsp_data
);
  bwc_state_e        state;
  logic [CS_W-1:0]   cs_q;
  logic              burst_q;
  logic [BEAT_W-1:0] len_q;
  logic [SEL_W-1:0]  sel_q;
  logic              inv_q;
  logic [1:0]        dly_q;

  // Named internal events
  logic in_addr, in_data, wait_act, beat_take, beat_final;
  assign in_addr = (state == ST_ADDR);
  assign in_data = (state == ST_DATA);

  bwc_wait_sel #(.NUM_WAIT(NUM_WAIT)) u_wsel (
    .wait_in (wait_in),
    .sel     (sel_q),
    .inv     (inv_q),
    .wait_act(wait_act)
  );

  bwc_pace u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (in_addr),
    .in_data (in_data),
    .wait_act(wait_act),
    .dly     (dly_q),
    .take    (beat_take)
  );

  bwc_beat_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (in_addr),
    .active    (in_data),
    .take      (beat_take),
    .len       (len_q),
    .final_beat(beat_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_q      <= '0;
      burst_q   <= 1'b0;
      len_q     <= BEAT_W'(1);
      sel_q     <= '0;
      inv_q     <= 1'b0;
      dly_q     <= 2'd0;
      bus_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      req_ack   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      req_ack   <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_ADDR;
          cs_q     <= req_cs;
          bus_addr <= req_addr;
          burst_q  <= cfg_burst[req_cs];
          len_q    <= beats_of(cfg_burst[req_cs], cfg_len[2*req_cs +: 2]);
          sel_q    <= cfg_wsel[SEL_W*req_cs +: SEL_W];
          inv_q    <= cfg_winv[req_cs];
          dly_q    <= dly_of(cfg_wdly[2*req_cs +: 2]);
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: if (beat_take) begin
          rsp_valid <= 1'b1;
          rsp_data  <= bus_rdata;
          if (beat_final) begin
            rsp_last <= 1'b1;
            req_ack  <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign bus_cs_n[i] = !((state != ST_IDLE) && (cs_q == CS_W'(i)));
  end
  assign bus_adv_n = !in_addr;
  assign bus_oe_n  = !in_data;

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  // R2
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |=> bus_adv_n && !bus_oe_n);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_adv_n));
  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !burst_q) |-> rsp_last);
  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> rsp_valid && rsp_last && (&bus_cs_n) && bus_oe_n);
  // R8
  beat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_data));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cs_q) && $stable(bus_addr));
endmodule

// File: tb/bwc_burst_ctrl_tb.sv
module bwc_burst_ctrl_tb;
  localparam int NCS = 4, NW = 4, AW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ack;
  logic [NCS-1:0] cfg_burst = '0, cfg_winv = '0;
  logic [2*NCS-1:0] cfg_len = '0, cfg_wsel = '0, cfg_wdly = '0;
  logic [NW-1:0] wait_in = '0;
  logic [NCS-1:0] bus_cs_n;
  logic bus_adv_n, bus_oe_n, rsp_valid, rsp_last;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata = '0, rsp_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bwc_burst_ctrl #(.NUM_CS(NCS), .NUM_WAIT(NW), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_addr(req_addr), .req_ack(req_ack), .cfg_burst(cfg_burst),
    .cfg_len(cfg_len), .cfg_wsel(cfg_wsel), .cfg_winv(cfg_winv),
    .cfg_wdly(cfg_wdly), .wait_in(wait_in), .bus_cs_n(bus_cs_n),
    .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .rsp_data(rsp_data)
  );

  function automatic int exp_len(bit b, int code);
    if (!b) return 1;
    return (code == 3) ? 4 : (4 << code);
  endfunction

  function automatic int exp_dly(int code);
    return (code > 2) ? 2 : code;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int cs, input bit b, input int code, input int sel,
                         input bit inv, input int d);
    cfg_burst[cs]      = b;
    cfg_len[2*cs +: 2] = code[1:0];
    cfg_wsel[2*cs +: 2] = sel[1:0];
    cfg_winv[cs]       = inv;
    cfg_wdly[2*cs +: 2] = d[1:0];
  endtask

  // mode 0: no wait, 1: light random, 2: heavy random, 3: held then re-raised after each beat
  task automatic run(input int cs, input int mode, input bit poke);
    int len, d, sel, quiet, beat, k;
    bit inv, act, take, prev_take, poked;
    logic [AW-1:0] a;
    logic [NW-1:0] w;
    logic [DW-1:0] dat;
    len = exp_len(cfg_burst[cs], int'(cfg_len[2*cs +: 2]));
    d = exp_dly(int'(cfg_wdly[2*cs +: 2]));
    sel = int'(cfg_wsel[2*cs +: 2]);
    inv = cfg_winv[cs];
    a = AW'($urandom);
    @(negedge clk);
    req_cs = 2'(cs); req_addr = a; req_valid = 1'b1; wait_in = NW'($urandom);
    @(negedge clk);
    req_valid = 1'b0;
    // R2 address phase
    chk(bus_cs_n == ~(NCS'(1) << cs), "R2 cs in address phase", int'(bus_cs_n), int'(~(NCS'(1) << cs)));
    chk(bus_adv_n == 1'b0 && bus_oe_n == 1'b1, "R2 strobes in address phase", int'({bus_adv_n, bus_oe_n}), 1);
    chk(bus_addr == a, "R2 address", int'(bus_addr), int'(a));
    // R8 selected wait driven active during the address phase
    w = NW'($urandom); w[sel] = 1'b1 ^ inv; wait_in = w;
    @(negedge clk);
    quiet = 0; beat = 0; k = 0; prev_take = 0; poked = 0;
    forever begin
      chk(bus_oe_n == 1'b0 && bus_adv_n == 1'b1, "R2 strobes in data phase", int'({bus_oe_n, bus_adv_n}), 1);
      chk(bus_cs_n == ~(NCS'(1) << cs), "R2 cs held in data phase", int'(bus_cs_n), int'(~(NCS'(1) << cs)));
      case (mode)
        0: act = 1'b0;
        1: act = ($urandom % 100) < 30;
        2: act = ($urandom % 100) < 60;
        default: act = (k < 3) || prev_take;
      endcase
      w = NW'($urandom); w[sel] = act ^ inv;   // R7 other inputs random
      wait_in = w;
      dat = DW'($urandom); bus_rdata = dat;
      take = !act && (quiet >= d);
      quiet = act ? 0 : ((quiet < 2) ? quiet + 1 : 2);
      if (poke && !poked && beat >= 1) begin
        req_valid = 1'b1; req_cs = 2'(cs + 1); poked = 1;   // R10
      end
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      chk(rsp_valid == take, "R5/R6 beat timing", int'(rsp_valid), int'(take));
      if (take) begin
        chk(rsp_data == dat, "R9 beat data", int'(rsp_data), int'(dat));
        chk(rsp_last == (beat == len - 1), "R4 last flag", int'(rsp_last), int'(beat == len - 1));
        if (beat == len - 1) begin
          chk(req_ack == 1'b1, "R9 ack on final beat", int'(req_ack), 1);
          chk(&bus_cs_n && bus_oe_n, "R9 bus released", int'({bus_cs_n, bus_oe_n}), 31);
          break;
        end
        beat++;
      end else begin
        chk(req_ack == 1'b0, "R9 no early ack", int'(req_ack), 0);
      end
      prev_take = take;
      if (rsp_last && !take) break;
    end
    chk(beat + 1 == len, "R3/R4 beat count", beat + 1, len);
    wait_in = NW'($urandom);
    @(negedge clk);
    chk(&bus_cs_n && bus_adv_n, "R10 idle after ack", int'({bus_cs_n, bus_adv_n}), 31);
    chk(req_ack == 1'b0 && rsp_valid == 1'b0, "R9 single-cycle ack", int'({req_ack, rsp_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    wait_in = NW'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(&bus_cs_n && bus_adv_n && bus_oe_n, "R1 bus idle in reset", int'({bus_cs_n, bus_adv_n, bus_oe_n}), 63);
    chk(!rsp_valid && !rsp_last && !req_ack, "R1 host outputs in reset", int'({rsp_valid, rsp_last, req_ack}), 0);
    rst_n = 1'b1;
    // R8 wait toggles while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); wait_in = NW'($urandom);
      chk(&bus_cs_n && rsp_valid == 1'b0, "R8 idle ignores wait", int'({bus_cs_n, rsp_valid}), 30);
    end
    // Directed cases
    set_cfg(0, 0, 0, 0, 0, 0); run(0, 0, 0);   // R3 single
    set_cfg(1, 1, 0, 1, 0, 0); run(1, 0, 1);   // R4 four beats, R10 poke
    set_cfg(2, 1, 1, 2, 0, 1); run(2, 3, 0);   // R6 re-raise, eight beats
    set_cfg(3, 1, 2, 3, 1, 2); run(3, 1, 1);   // R7 inverted, sixteen beats
    set_cfg(0, 1, 3, 3, 0, 3); run(0, 0, 0);   // R4 code 3, R5 delay code 3
    set_cfg(1, 0, 2, 2, 1, 2); run(1, 3, 0);   // R3 single with delay
    set_cfg(2, 1, 2, 0, 0, 2); run(2, 3, 1);   // R6 long burst re-raised
    // Random mix
    for (int n = 0; n < 60; n++) begin
      int cs;
      cs = $urandom % NCS;
      set_cfg(cs, 1'($urandom), $urandom % 4, $urandom % 4, 1'($urandom), $urandom % 4);
      run(cs, $urandom % 4, 1'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule